// File: doc/BRIEF.md
# Per-Channel Sample Buffer with Staleness Flags

This block keeps one 12-bit measurement of the controlled device for each of 32 logical output channels. Every beam tick the block learns which channel (if any) drove the output level at that tick. A short shift pipeline remembers those channel numbers, so that one, two or three beams later, once the device has settled, a conversion is started for the right channel. The first conversion result that arrives after that start is written into that channel's slot.

Each slot has a stale flag. The flag is set when the host writes a new level for that channel, and it is cleared when a fresh result for the channel is stored. If the analog output is turned off while a conversion is in flight, the flag of the converting channel is set and stays set when that result lands. The host reads the slots in order through a 5-bit pointer, two 16-bit words per slot. A read that lands in the same cycle as an internal slot write gets a busy answer and leaves the read position where it was. Turning the samples into a float word and running the converter itself are handled by other blocks.

Top module: `sample_buf`

## Requirements
- R1: After reset or a clear pulse, every stale flag reads 1, every stored sample reads 0, the pointer is 0, the next read returns the first word, and no capture is pending.
- R2: A level write for channel c sets the stale flag of slot c in the next cycle.
- R3: With depth select s (0, 1 or 2 meaning 1, 2 or 3 beams), a load of channel c on a beam tick starts a conversion on the s+1-th following beam tick. The next conversion-valid pulse stores its 12-bit data in slot c and clears slot c's flag.
- R4: A beam tick with no load (a do-nothing beam) pushes an empty stage, so no conversion starts when that stage falls due. Depth select 3 behaves as 2.
- R5: A falling edge of the output enable while a conversion is in flight sets that channel's flag. The result is still stored when it completes, but the flag stays set.
- R6: When a level write and a completed conversion hit the same slot in the same cycle, the flag ends set.
- R7: A read returns a response one cycle later. The first word is the sample in bits 11:0 with zeros above. The second word holds the stale flag in bit 0 with zeros above. The pointer advances after the second word and wraps from 31 to 0.
- R8: A pointer write loads the pointer (visible on the pointer output the next cycle) and makes the next read return the first word.
- R9: A read in a cycle where a conversion result is being stored answers with q=0 and data 0, and neither the pointer nor the word position moves.
- R10: A conversion-valid pulse with no conversion in flight changes no slot and no flag.
- R11: A read in the same cycle as a pointer write gets no response. The pointer write takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr_i | input | 1 | Module clear pulse, same effect as reset |
| beam_i | input | 1 | Beam tick pulse |
| load_vld_i | input | 1 | A channel was loaded on this beam tick (0 = do-nothing) |
| load_ch_i | input | 5 | Channel loaded on this beam tick |
| depth_sel_i | input | 2 | Settling depth: 0/1/2 = 1/2/3 beams, 3 acts as 2 |
| out_en_i | input | 1 | Analog output enable level |
| adc_vld_i | input | 1 | Conversion result valid |
| adc_data_i | input | 12 | Conversion result |
| lvl_wr_i | input | 1 | Host writes a channel level |
| lvl_ch_i | input | 5 | Channel whose level is written |
| ptr_wr_i | input | 1 | Host writes the read pointer |
| ptr_din_i | input | 5 | New pointer value |
| rd_i | input | 1 | Host read of one buffer word |
| rd_ptr_o | output | 5 | Current read pointer |
| rd_rsp_o | output | 1 | Read response valid |
| rd_q_o | output | 1 | 1 = read served, 0 = busy |
| rd_data_o | output | 16 | Read word |

## Verification
The bench aims at the depth pipeline. It uses do-nothing beams, stray conversion pulses between beams, and the clamped depth code. A pipeline tapped at the wrong stage would store a result in a neighbour's slot or under the wrong channel. It also drives the three flag races: a disable during a conversion, a level write that coincides with completion, and completion alone. Getting the priority wrong there would leave stale data marked fresh. Reads that collide with a store, reads across the 31-to-0 wrap, and reads issued together with a pointer write show whether the pointer slips or a word gets skipped.

// File: rtl/sb_pkg.sv
// Shared definitions for the sample buffer.
// Assumes: nothing beyond IEEE 1800-2017.
package sb_pkg;

    // Which of the two host words the next read returns.
    typedef enum logic {
        PH_SAMPLE = 1'b0,
        PH_FLAG   = 1'b1
    } word_ph_e;

    // Map a depth select code onto a pipeline tap index, clamped to the last stage.
    function automatic int unsigned tap_of(input logic [1:0] sel, input int unsigned max_depth);
        int unsigned s;
        s = int'(sel);
        return (s > max_depth - 1) ? max_depth - 1 : s;
    endfunction

endpackage

// File: rtl/sb_chan_pipe.sv
// Pipeline of pending channel numbers, shifted on each beam tick.
// Stage 0 holds the load of the previous beam. A tap chosen by the depth
// select starts a conversion on the current beam for the stage's channel.
// Assumes: beam_i is a single-cycle pulse; depth_sel_i is stable around beams.
module sb_chan_pipe #(
    parameter int unsigned CH_W      = 5,
    parameter int unsigned MAX_DEPTH = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr_i,
    input  logic            beam_i,
    input  logic            load_vld_i,
    input  logic [CH_W-1:0] load_ch_i,
    input  logic [1:0]      depth_sel_i,
    output logic            start_o,
    output logic [CH_W-1:0] start_ch_o
);
    import sb_pkg::*;

    logic [MAX_DEPTH-1:0] vld_q;
    logic [CH_W-1:0]      ch_q [MAX_DEPTH];
    int unsigned          tap;

    generate
        for (genvar g = 0; g < MAX_DEPTH; g++) begin : g_stage
            if (g == 0) begin : g_head
                // Capture the current beam's load into the head stage.
                always_ff @(posedge clk) begin
                    if (!rst_n || clr_i) begin
                        vld_q[0] <= 1'b0;
                        ch_q[0]  <= '0;
                    end else if (beam_i) begin
                        vld_q[0] <= load_vld_i;
                        ch_q[0]  <= load_ch_i;
                    end
                end
            end else begin : g_tail
                // Shift the older stages by one beam.
                always_ff @(posedge clk) begin
                    if (!rst_n || clr_i) begin
                        vld_q[g] <= 1'b0;
                        ch_q[g]  <= '0;
                    end else if (beam_i) begin
                        vld_q[g] <= vld_q[g-1];
                        ch_q[g]  <= ch_q[g-1];
                    end
                end
            end
        end
    endgenerate

    // Select the stage that is due on this beam.
    always_comb begin
        tap        = tap_of(depth_sel_i, MAX_DEPTH);
        start_o    = beam_i && vld_q[tap];
        start_ch_o = ch_q[tap];
    end

endmodule

// File: rtl/sb_store.sv
// Sample slots, stale flags and the conversion in flight.
// A start opens a conversion for one channel. The next adc_vld_i stores the
// sample in that slot. An output-enable fall during the conversion taints it.
// Assumes: at most one conversion in flight; a new start replaces the old one.
module sb_store #(
    parameter int unsigned N_CH  = 32,
    parameter int unsigned CH_W  = 5,
    parameter int unsigned SMP_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             start_i,
    input  logic [CH_W-1:0]  start_ch_i,
    input  logic             out_en_i,
    input  logic             adc_vld_i,
    input  logic [SMP_W-1:0] adc_data_i,
    input  logic             lvl_wr_i,
    input  logic [CH_W-1:0]  lvl_ch_i,
    input  logic [CH_W-1:0]  rd_idx_i,
    output logic [SMP_W-1:0] rd_smp_o,
    output logic             rd_flag_o,
    output logic             wr_busy_o
);
    logic [SMP_W-1:0] smp_q [N_CH];
    logic [N_CH-1:0]  flag_q;
    logic             busy_q, taint_q, en_q;
    logic [CH_W-1:0]  cch_q;
    logic             done, en_fall, taint_eff;

    // Decode completion and the enable fall in this cycle.
    always_comb begin
        done      = busy_q && adc_vld_i;
        en_fall   = en_q && !out_en_i;
        taint_eff = taint_q || (busy_q && en_fall);
        wr_busy_o = done;
        rd_smp_o  = smp_q[rd_idx_i];
        rd_flag_o = flag_q[rd_idx_i];
    end

    // Track the conversion in flight and remember the enable level.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            busy_q  <= 1'b0;
            taint_q <= 1'b0;
            cch_q   <= '0;
            en_q    <= 1'b0;
        end else begin
            en_q <= out_en_i;
            if (start_i) begin
                busy_q  <= 1'b1;
                taint_q <= 1'b0;
                cch_q   <= start_ch_i;
            end else if (done) begin
                busy_q <= 1'b0;
            end else if (busy_q && en_fall) begin
                taint_q <= 1'b1;
            end
        end
    end

    // Store completed samples in their channel's slot.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            for (int i = 0; i < int'(N_CH); i++) smp_q[i] <= '0;
        end else if (done) begin
            smp_q[cch_q] <= adc_data_i;
        end
    end

    generate
        for (genvar g = 0; g < N_CH; g++) begin : g_flag
            logic hit_set, hit_clr;
            always_comb begin
                hit_set = (lvl_wr_i && lvl_ch_i == CH_W'(g))
                       || (busy_q && en_fall && cch_q == CH_W'(g));
                hit_clr = done && !taint_eff && cch_q == CH_W'(g);
            end
            // Per-slot stale flag: set wins over clear.
            always_ff @(posedge clk) begin
                if (!rst_n || clr_i)  flag_q[g] <= 1'b1;
                else if (hit_set)     flag_q[g] <= 1'b1;
                else if (hit_clr)     flag_q[g] <= 1'b0;
            end
        end
    endgenerate

    AST_LVL_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        $past(lvl_wr_i) |-> flag_q[$past(lvl_ch_i)]); // R2
    AST_CLR_ALL_STALE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(clr_i) |-> (&flag_q)); // R1
    AST_TAINT_KEEPS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(done) && $past(taint_eff) && !$past(clr_i)) |-> flag_q[$past(cch_q)]); // R5

endmodule

// File: rtl/sb_host_rd.sv
// Host-side sequential reader: pointer, word position and registered answer.
// Assumes: rd_i and ptr_wr_i are single-cycle strobes; busy_i marks a slot write.
module sb_host_rd #(
    parameter int unsigned CH_W   = 5,
    parameter int unsigned SMP_W  = 12,
    parameter int unsigned WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              ptr_wr_i,
    input  logic [CH_W-1:0]   ptr_din_i,
    input  logic              rd_i,
    input  logic              busy_i,
    input  logic [SMP_W-1:0]  smp_i,
    input  logic              flag_i,
    output logic [CH_W-1:0]   ptr_o,
    output logic              rsp_o,
    output logic              q_o,
    output logic [WORD_W-1:0] data_o
);
    import sb_pkg::*;

    localparam logic [CH_W-1:0] LAST = '1;

    logic [CH_W-1:0] ptr_q;
    word_ph_e        ph_q;
    logic [WORD_W-1:0] word;

    // Build the word that the current position selects.
    always_comb begin
        if (ph_q == PH_SAMPLE) word = {{(WORD_W-SMP_W){1'b0}}, smp_i};
        else                   word = {{(WORD_W-1){1'b0}}, flag_i};
    end

    // Serve reads, advance the position, and load the pointer.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            ptr_q  <= '0;
            ph_q   <= PH_SAMPLE;
            rsp_o  <= 1'b0;
            q_o    <= 1'b0;
            data_o <= '0;
        end else begin
            rsp_o  <= 1'b0;
            q_o    <= 1'b0;
            data_o <= '0;
            if (ptr_wr_i) begin
                ptr_q <= ptr_din_i;
                ph_q  <= PH_SAMPLE;
            end else if (rd_i) begin
                rsp_o <= 1'b1;
                if (!busy_i) begin
                    q_o    <= 1'b1;
                    data_o <= word;
                    if (ph_q == PH_FLAG) begin
                        ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
                        ph_q  <= PH_SAMPLE;
                    end else begin
                        ph_q <= PH_FLAG;
                    end
                end
            end
        end
    end

    assign ptr_o = ptr_q;

    AST_BUSY_NO_ADV: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_o && !q_o) |-> (ptr_q == $past(ptr_q) && ph_q == $past(ph_q))); // R9
    AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_o && q_o && $past(ptr_q) == LAST && $past(ph_q) == PH_FLAG) |-> ptr_q == '0); // R7
    AST_PTR_WR_NO_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ptr_wr_i) |-> !rsp_o); // R11

endmodule

// File: rtl/sample_buf.sv
// Top of the per-channel sample buffer: channel pipeline, slot store and
// host reader wired together.
// Assumes: one clock domain; all strobes are single-cycle pulses.
module sample_buf #(
    parameter int unsigned N_CH      = 32,
    parameter int unsigned SMP_W     = 12,
    parameter int unsigned WORD_W    = 16,
    parameter int unsigned MAX_DEPTH = 3,
    localparam int unsigned CH_W     = $clog2(N_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              beam_i,
    input  logic              load_vld_i,
    input  logic [CH_W-1:0]   load_ch_i,
    input  logic [1:0]        depth_sel_i,
    input  logic              out_en_i,
    input  logic              adc_vld_i,
    input  logic [SMP_W-1:0]  adc_data_i,
    input  logic              lvl_wr_i,
    input  logic [CH_W-1:0]   lvl_ch_i,
    input  logic              ptr_wr_i,
    input  logic [CH_W-1:0]   ptr_din_i,
    input  logic              rd_i,
    output logic [CH_W-1:0]   rd_ptr_o,
    output logic              rd_rsp_o,
    output logic              rd_q_o,
    output logic [WORD_W-1:0] rd_data_o
);
    logic             start;
    logic [CH_W-1:0]  start_ch;
    logic [SMP_W-1:0] smp;
    logic             flag, wr_busy;

    sb_chan_pipe #(.CH_W(CH_W), .MAX_DEPTH(MAX_DEPTH)) pipe_i (
        .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .beam_i(beam_i),
        .load_vld_i(load_vld_i), .load_ch_i(load_ch_i), .depth_sel_i(depth_sel_i),
        .start_o(start), .start_ch_o(start_ch)
    );

    sb_store #(.N_CH(N_CH), .CH_W(CH_W), .SMP_W(SMP_W)) store_i (
        .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .start_i(start), .start_ch_i(start_ch),
        .out_en_i(out_en_i), .adc_vld_i(adc_vld_i), .adc_data_i(adc_data_i),
        .lvl_wr_i(lvl_wr_i), .lvl_ch_i(lvl_ch_i), .rd_idx_i(rd_ptr_o),
        .rd_smp_o(smp), .rd_flag_o(flag), .wr_busy_o(wr_busy)
    );

    sb_host_rd #(.CH_W(CH_W), .SMP_W(SMP_W), .WORD_W(WORD_W)) rd_i_u (
        .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .ptr_wr_i(ptr_wr_i), .ptr_din_i(ptr_din_i),
        .rd_i(rd_i), .busy_i(wr_busy), .smp_i(smp), .flag_i(flag),
        .ptr_o(rd_ptr_o), .rsp_o(rd_rsp_o), .q_o(rd_q_o), .data_o(rd_data_o)
    );

endmodule

// File: tb/sample_buf_tb.sv
// Bench: behavioural reference model compared against the design every cycle.
module sample_buf_tb_top;
    logic clk = 1'b0, rst_n = 1'b0, clr = 1'b0;
    logic beam = 0, ld_vld = 0, out_en = 0, adc_vld = 0, lvl_wr = 0, ptr_wr = 0, rd = 0;
    logic [4:0] ld_ch = 0, lvl_ch = 0, ptr_din = 0;
    logic [1:0] dsel = 0;
    logic [11:0] adc_data = 0;
    logic [4:0] rd_ptr;
    logic rsp, q;
    logic [15:0] data;

    int checks = 0, errors = 0;
    string cur_req = "R1";
    bit chk_on = 0;

    always #4 clk = ~clk;

    sample_buf dut_i (
        .clk(clk), .rst_n(rst_n), .clr_i(clr), .beam_i(beam), .load_vld_i(ld_vld),
        .load_ch_i(ld_ch), .depth_sel_i(dsel), .out_en_i(out_en), .adc_vld_i(adc_vld),
        .adc_data_i(adc_data), .lvl_wr_i(lvl_wr), .lvl_ch_i(lvl_ch), .ptr_wr_i(ptr_wr),
        .ptr_din_i(ptr_din), .rd_i(rd), .rd_ptr_o(rd_ptr), .rd_rsp_o(rsp), .rd_q_o(q),
        .rd_data_o(data)
    );

    // ---------------- reference model ----------------
    int m_smp [32];
    bit m_flg [32];
    int m_pipe [$];
    bit m_busy, m_taint, m_enq, m_ph;
    int m_cch, m_ptr;
    bit e_rsp, e_q;
    int e_data;

    task automatic m_reset();
        for (int i = 0; i < 32; i++) begin m_smp[i] = 0; m_flg[i] = 1; end
        m_pipe = {-1, -1, -1};
        m_busy = 0; m_taint = 0; m_enq = 0; m_cch = 0; m_ptr = 0; m_ph = 0;
        e_rsp = 0; e_q = 0; e_data = 0;
    endtask

    always @(posedge clk) begin
        if (!rst_n || clr) m_reset();
        else begin
            bit fall, done, start, teff;
            int depth, sch;
            fall = m_enq && !out_en;
            done = m_busy && adc_vld;
            e_rsp = 0; e_q = 0; e_data = 0;
            if (ptr_wr) begin m_ptr = ptr_din; m_ph = 0; end
            else if (rd) begin
                e_rsp = 1;
                if (!done) begin
                    e_q = 1;
                    e_data = m_ph ? int'(m_flg[m_ptr]) : m_smp[m_ptr];
                    if (m_ph) m_ptr = (m_ptr + 1) % 32;
                    m_ph = !m_ph;
                end
            end
            depth = (dsel == 0) ? 1 : (dsel == 1) ? 2 : 3;
            sch = m_pipe[depth-1];
            start = beam && sch >= 0;
            teff = m_taint || (m_busy && fall);
            if (m_busy && fall) m_flg[m_cch] = 1;
            if (done) begin
                m_smp[m_cch] = adc_data;
                if (!teff) m_flg[m_cch] = 0;
            end
            if (lvl_wr) m_flg[lvl_ch] = 1;
            if (start) begin m_busy = 1; m_cch = sch; m_taint = 0; end
            else if (done) m_busy = 0;
            else if (m_busy && fall) m_taint = 1;
            if (beam) begin
                m_pipe.push_front(ld_vld ? int'(ld_ch) : -1);
                void'(m_pipe.pop_back());
            end
            m_enq = out_en;
        end
    end

    // ---------------- comparison on every cycle ----------------
    task automatic chk(string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual %0h expected %0h", cur_req, what, act, exp);
        end
    endtask

    always @(negedge clk) if (chk_on) begin
        chk("pointer", int'(rd_ptr), m_ptr);
        chk("rsp", int'(rsp), int'(e_rsp));
        if (e_rsp) begin
            chk("q", int'(q), int'(e_q));
            chk("data", int'(data), e_data);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic idle(int n = 1);
        repeat (n) @(negedge clk);
    endtask
    task automatic do_beam(bit v, int ch);
        beam = 1; ld_vld = v; ld_ch = 5'(ch); idle(); beam = 0; ld_vld = 0;
    endtask
    task automatic do_adc(int d);
        adc_vld = 1; adc_data = 12'(d); idle(); adc_vld = 0;
    endtask
    task automatic do_rd();
        rd = 1; idle(); rd = 0;
    endtask
    task automatic set_ptr(int p);
        ptr_wr = 1; ptr_din = 5'(p); idle(); ptr_wr = 0;
    endtask
    task automatic read_slot(int p);
        set_ptr(p); do_rd(); do_rd(); idle();
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired in %s", cur_req);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        idle(3); rst_n = 1; chk_on = 1; idle();
        cur_req = "R1"; repeat (4) do_rd(); idle();
        cur_req = "R8"; set_ptr(5); idle();
        cur_req = "R3"; out_en = 1; dsel = 0;
        do_beam(1, 5); idle(3); do_beam(0, 0); idle(2); do_adc(12'hABC); idle(); read_slot(5);
        cur_req = "R10"; do_adc(12'h111); read_slot(5);
        cur_req = "R2"; lvl_wr = 1; lvl_ch = 5; idle(); lvl_wr = 0; read_slot(5);
        cur_req = "R4"; dsel = 2;
        do_beam(1, 7); do_beam(0, 0); do_beam(0, 0); do_adc(12'h222); do_beam(0, 0);
        do_adc(12'h777); read_slot(7);
        do_beam(0, 0); do_beam(0, 0); do_beam(0, 0); do_adc(12'h333); read_slot(0);
        dsel = 1; do_beam(1, 8); do_beam(0, 0); do_beam(0, 0); do_adc(12'h888); read_slot(8);
        dsel = 3; do_beam(1, 12); do_beam(0, 0); do_beam(0, 0); do_beam(0, 0);
        do_adc(12'hC12); read_slot(12);
        cur_req = "R5"; dsel = 0;
        do_beam(1, 9); do_beam(0, 0); idle(); out_en = 0; idle(2); do_adc(12'h999);
        out_en = 1; read_slot(9);
        cur_req = "R6"; do_beam(1, 10); do_beam(0, 0); idle();
        adc_vld = 1; adc_data = 12'hAAA; lvl_wr = 1; lvl_ch = 10; idle();
        adc_vld = 0; lvl_wr = 0; read_slot(10);
        cur_req = "R9"; do_beam(1, 11); do_beam(0, 0); set_ptr(11);
        rd = 1; adc_vld = 1; adc_data = 12'hB0B; idle(); rd = 0; adc_vld = 0;
        do_rd(); do_rd(); idle();
        cur_req = "R7"; set_ptr(31); repeat (4) do_rd(); idle(2);
        cur_req = "R11"; ptr_wr = 1; ptr_din = 9; rd = 1; idle(); ptr_wr = 0; rd = 0;
        do_rd(); do_rd(); idle();
        cur_req = "R1"; clr = 1; idle(); clr = 0; do_rd(); do_rd(); read_slot(5); idle(2);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule